// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block sits between a set of wired peripheral interrupt lines and an upstream controller that takes interrupts as memory writes. Each line has its own configuration word with an enable, a trigger mode (active-high level or rising edge), a group code and a 10-bit vector. When a line fires, the block emits one posted write: the address comes from a programmable 64-bit target and the data is the line's vector.

A line in level mode in the non-secure group (code 0) sends a "set" write when it goes high and a "clear" write when it goes low. The set and clear targets are separate registers. The clear target is used exactly as software wrote it. Lines in the system-error group (code 4) use their own set target and never send a clear. Every other group code is stored but stays silent.

Events wait in per-line pending flags. A fixed priority picks the lowest line number first. Each write leaves through a valid/ready port that holds the message steady while the port is stalled.

Top module: `irq_msg_bridge`

## Requirements
- R1: There are `N_LINES` (default 207) inputs. Line n has a configuration word at byte offset 0x100 + 4n with fields vector [9:0], enable [24], edge mode [28] (0 = level) and group [31:29]. A read returns the stored fields and all other bits as zero, so writing 0xFFFFFFFF reads back as 0xF10003FF.
- R2: The target address words can be read back. The non-secure set address has its low word at 0x10 and high word at 0x14. The non-secure clear address has its low word at 0x18 and high word at 0x1C. The system-error set address has its low word at 0x50 and high word at 0x54. Each 64-bit target is {high, low}.
- R3: Writes to any other offset are ignored. This includes unaligned offsets and line words for n >= N_LINES. Reads of those offsets return zero.
- R4: For an enabled level-mode line in group 0, a rising input sends data {22'b0, vector} to the non-secure set address. A falling input then sends the same data to the non-secure clear address, unmodified.
- R5: An enabled edge-mode line sends exactly one set write per rising edge and nothing when it falls.
- R6: An enabled line in group 4 sends its set write to the system-error set address and never sends a clear write, in either mode.
- R7: A line whose enable bit is 0, or whose group is neither 0 nor 4, sends no write.
- R8: Pending events are granted to the lowest line number first. Within one line, a pending set is sent before a pending clear.
- R9: While msg_valid_o is high and msg_ready_i is low, the address and data stay unchanged and valid stays high.
- R10: No event is lost while the port is stalled. Repeated rises of an edge-mode line that is already pending merge into one write. A level line that rises again while its clear is still pending cancels that clear and sends nothing more.
- R11: Any write to a line's configuration word discards that line's undelivered events.
- R12: After reset, msg_valid_o is low and every configuration and address register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES | Wired interrupt lines, active high, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i (combinational) |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by upstream |
| msg_addr_o | output | 64 | Message target address |
| msg_data_o | output | 32 | Message data (vector, zero-extended) |

## Verification
One line can hold a pending set and a pending clear at the same time. This happens when a level line rises and falls while the port is stalled and another line's write occupies the output register. The bench sets up exactly this case and expects the other line's write, then the set, then the clear, in that order.

The reverse case is also driven. A fall followed by a new rise during a stall must leave no clear and no extra set, and a later fall must still produce its clear.

The bench also runs a sweep over enable, trigger mode and all four group codes on lines at both ends of the range. Its expected write lists are built from the field rules.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int VecW = 10;

  localparam logic [2:0] GRP_NS     = 3'd0;
  localparam logic [2:0] GRP_SEC    = 3'd1;
  localparam logic [2:0] GRP_SYSERR = 3'd4;
  localparam logic [2:0] GRP_ERR2   = 3'd5;

  localparam logic [11:0] OFS_NS_SET_LO = 12'h010;
  localparam logic [11:0] OFS_NS_SET_HI = 12'h014;
  localparam logic [11:0] OFS_NS_CLR_LO = 12'h018;
  localparam logic [11:0] OFS_NS_CLR_HI = 12'h01C;
  localparam logic [11:0] OFS_SE_SET_LO = 12'h050;
  localparam logic [11:0] OFS_SE_SET_HI = 12'h054;
  localparam logic [11:0] OFS_LINE_BASE = 12'h100;

  typedef struct packed {
    logic [2:0]      grp;
    logic            edge_md;
    logic            en;
    logic [VecW-1:0] vec;
  } line_cfg_t;

  function automatic logic [31:0] cfg_to_word(line_cfg_t c);
    return {c.grp, c.edge_md, 3'b000, c.en, 14'd0, c.vec};
  endfunction

  function automatic line_cfg_t word_to_cfg(logic [31:0] w);
    line_cfg_t c;
    c.grp     = w[31:29];
    c.edge_md = w[28];
    c.en      = w[24];
    c.vec     = w[VecW-1:0];
    return c;
  endfunction

endpackage

// File: rtl/irq_msg_cfg.sv
module irq_msg_cfg
  import irq_msg_pkg::*;
#(
  parameter int N_LINES = 207,
  parameter int AW      = 12,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output line_cfg_t [N_LINES-1:0]   cfg_o,
  output logic [N_LINES-1:0]        line_wr_o,
  output logic [63:0]               ns_set_o,
  output logic [63:0]               ns_clr_o,
  output logic [63:0]               se_set_o
);

  logic [AW-1:0] line_off;
  logic [AW-3:0] line_num;
  logic [LW-1:0] line_sel;
  logic          line_hit;
  logic [31:0]   ns_set_lo, ns_set_hi, ns_clr_lo, ns_clr_hi, se_set_lo, se_set_hi;

  assign line_off = addr_i - AW'(OFS_LINE_BASE);
  assign line_num = line_off[AW-1:2];
  assign line_sel = line_num[LW-1:0];
  assign line_hit = (addr_i >= AW'(OFS_LINE_BASE)) && (addr_i[1:0] == 2'b00)
                    && (int'(line_num) < N_LINES);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_wr_o[i] = we_i && line_hit && (line_num == (AW-2)'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cfg_o[i] <= '0;
      else if (line_wr_o[i]) cfg_o[i] <= word_to_cfg(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_set_lo <= '0; ns_set_hi <= '0; ns_clr_lo <= '0;
      ns_clr_hi <= '0; se_set_lo <= '0; se_set_hi <= '0;
    end else if (we_i) begin
      case (addr_i)
        AW'(OFS_NS_SET_LO): ns_set_lo <= wdata_i;
        AW'(OFS_NS_SET_HI): ns_set_hi <= wdata_i;
        AW'(OFS_NS_CLR_LO): ns_clr_lo <= wdata_i;
        AW'(OFS_NS_CLR_HI): ns_clr_hi <= wdata_i;
        AW'(OFS_SE_SET_LO): se_set_lo <= wdata_i;
        AW'(OFS_SE_SET_HI): se_set_hi <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ns_set_o = {ns_set_hi, ns_set_lo};
  assign ns_clr_o = {ns_clr_hi, ns_clr_lo};
  assign se_set_o = {se_set_hi, se_set_lo};

  always_comb begin
    rdata_o = '0;
    if (line_hit) begin
      rdata_o = cfg_to_word(cfg_o[line_sel]);
    end else begin
      case (addr_i)
        AW'(OFS_NS_SET_LO): rdata_o = ns_set_lo;
        AW'(OFS_NS_SET_HI): rdata_o = ns_set_hi;
        AW'(OFS_NS_CLR_LO): rdata_o = ns_clr_lo;
        AW'(OFS_NS_CLR_HI): rdata_o = ns_clr_hi;
        AW'(OFS_SE_SET_LO): rdata_o = se_set_lo;
        AW'(OFS_SE_SET_HI): rdata_o = se_set_hi;
        default:            rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_msg_tracker.sv
module irq_msg_tracker #(
  parameter int N_LINES = 207,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] arm_set_i,
  input  logic [N_LINES-1:0] arm_clr_i,
  input  logic [N_LINES-1:0] flush_i,
  input  logic               take_i,
  input  logic [LW-1:0]      take_idx_i,
  input  logic               take_clr_i,
  output logic [N_LINES-1:0] set_pend_o,
  output logic [N_LINES-1:0] clr_pend_o
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_trk
    logic [2:0] sync_q;
    logic       rise, fall, take_s, take_c, cancel;

    assign rise   = sync_q[1] & ~sync_q[2];
    assign fall   = ~sync_q[1] & sync_q[2];
    assign take_s = take_i && (take_idx_i == LW'(i)) && !take_clr_i;
    assign take_c = take_i && (take_idx_i == LW'(i)) && take_clr_i;
    // re-rise before the clear went out: upstream still sees the line asserted
    assign cancel = rise && arm_clr_i[i] && clr_pend_o[i] && !take_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q        <= '0;
        set_pend_o[i] <= 1'b0;
        clr_pend_o[i] <= 1'b0;
      end else begin
        sync_q <= {sync_q[1:0], irq_i[i]};
        if (flush_i[i]) begin
          set_pend_o[i] <= 1'b0;
          clr_pend_o[i] <= 1'b0;
        end else begin
          set_pend_o[i] <= (set_pend_o[i] & ~take_s) | (rise & arm_set_i[i] & ~cancel);
          clr_pend_o[i] <= cancel ? 1'b0
                         : ((clr_pend_o[i] & ~take_c) | (fall & arm_clr_i[i]));
        end
      end
    end
  end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
  parameter int N_LINES = 207,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] req_i,
  output logic               any_o,
  output logic [LW-1:0]      idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = LW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import irq_msg_pkg::*;
#(
  parameter int N_LINES = 207,
  parameter int AW      = 12,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);

  line_cfg_t [N_LINES-1:0] cfg_q;
  logic [N_LINES-1:0]      line_wr, arm_set, arm_clr, set_pend, clr_pend, req;
  logic [63:0]             ns_set, ns_clr, se_set;
  logic                    gnt_any, load, load_clr;
  logic [LW-1:0]           gnt_idx;
  line_cfg_t               gnt_cfg;

  irq_msg_cfg #(.N_LINES(N_LINES), .AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .cfg_o(cfg_q), .line_wr_o(line_wr),
    .ns_set_o(ns_set), .ns_clr_o(ns_clr), .se_set_o(se_set)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_arm
    assign arm_set[i] = cfg_q[i].en && (cfg_q[i].grp == GRP_NS || cfg_q[i].grp == GRP_SYSERR);
    assign arm_clr[i] = cfg_q[i].en && (cfg_q[i].grp == GRP_NS) && !cfg_q[i].edge_md;
  end

  irq_msg_tracker #(.N_LINES(N_LINES)) u_trk (
    .clk_i, .rst_ni, .irq_i,
    .arm_set_i(arm_set), .arm_clr_i(arm_clr), .flush_i(line_wr),
    .take_i(load), .take_idx_i(gnt_idx), .take_clr_i(load_clr),
    .set_pend_o(set_pend), .clr_pend_o(clr_pend)
  );

  assign req = set_pend | clr_pend;

  irq_msg_arb #(.N_LINES(N_LINES)) u_arb (.req_i(req), .any_o(gnt_any), .idx_o(gnt_idx));

  assign load     = gnt_any && (!msg_valid_o || msg_ready_i);
  assign load_clr = !set_pend[gnt_idx];
  assign gnt_cfg  = cfg_q[gnt_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else if (load) begin
      msg_valid_o <= 1'b1;
      msg_data_o  <= {{(32-VecW){1'b0}}, gnt_cfg.vec};
      if (load_clr)                      msg_addr_o <= ns_clr;
      else if (gnt_cfg.grp == GRP_SYSERR) msg_addr_o <= se_set;
      else                               msg_addr_o <= ns_set;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_msg_bridge_chk.sv
module irq_msg_bridge_chk #(
  parameter int N_LINES = 207,
  localparam int LW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [63:0]        msg_addr_o,
  input logic [31:0]        msg_data_o,
  input logic [N_LINES-1:0] req,
  input logic               load,
  input logic [LW-1:0]      gnt_idx
);

  logic lower_busy;
  always_comb begin
    lower_busy = 1'b0;
    for (int i = 0; i < N_LINES; i++)
      if (i < int'(gnt_idx) && req[i]) lower_busy = 1'b1;
  end

  // R9
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  // R4
  a_r4_data_is_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:10] == '0);

  // R8
  a_r8_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> req[gnt_idx]);

  // R8
  a_r8_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> !lower_busy);

  // R12
  a_r12_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_valid_o && !load |=> !msg_valid_o);

endmodule

bind irq_msg_bridge irq_msg_bridge_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o), .req(req), .load(load), .gnt_idx(gnt_idx)
);

// File: tb/sim_irq_msg_bridge.sv
module sim_irq_msg_bridge;
  localparam int CLK_P = 10;
  localparam int NL    = 207;
  localparam logic [63:0] NS_SET = 64'h0000_00AB_F000_0040;
  localparam logic [63:0] NS_CLR = 64'h0000_00AB_F000_0048;
  localparam logic [63:0] SE_SET = 64'h0000_0012_3456_7000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic          we = 1'b0, ready = 1'b1;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          valid;
  logic [63:0]   maddr;
  logic [31:0]   mdata;

  int checks = 0, fails = 0;
  logic [63:0] q_a[$], e_a[$];
  logic [31:0] q_d[$], e_d[$];

  always #(CLK_P/2) clk = ~clk;

  irq_msg_bridge #(.N_LINES(NL), .AW(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .msg_valid_o(valid), .msg_ready_i(ready),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  always begin
    @(negedge clk); #1;
    if (rst_n && valid && ready) begin q_a.push_back(maddr); q_d.push_back(mdata); end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, req, 64'(rdata), 64'(exp));
  endtask

  function automatic logic [31:0] cw(input bit en, input bit ed, input logic [2:0] g, input logic [9:0] v);
    return {g, ed, 3'b000, en, 14'd0, v};
  endfunction

  function automatic logic [11:0] lo(input int n);
    return 12'(32'h100 + 4*n);
  endfunction

  task automatic expect_msg(input logic [63:0] a, input logic [9:0] v);
    e_a.push_back(a); e_d.push_back({22'd0, v});
  endtask

  task automatic compare(input string req);
    tick(20);
    chk(q_a.size() == e_a.size(), req, 64'(q_a.size()), 64'(e_a.size()));
    if (q_a.size() == e_a.size())
      for (int k = 0; k < q_a.size(); k++) begin
        chk(q_a[k] == e_a[k], req, q_a[k], e_a[k]);
        chk(q_d[k] == e_d[k], req, 64'(q_d[k]), 64'(e_d[k]));
      end
    q_a.delete(); q_d.delete(); e_a.delete(); e_d.delete();
  endtask

  task automatic pulse(input int n, input int hi, input int lw);
    @(negedge clk); irq[n] = 1'b1; tick(hi);
    irq[n] = 1'b0; tick(lw);
  endtask

  initial begin
    logic [2:0] grps [4] = '{3'd0, 3'd1, 3'd4, 3'd5};
    int lines [5] = '{0, 1, 57, 205, 206};
    tick(3); #1;
    chk(valid == 1'b0, "R12", 64'(valid), 64'd0);
    rst_n = 1'b1;
    rd(12'h010, 32'd0, "R12"); rd(lo(0), 32'd0, "R12"); rd(lo(206), 32'd0, "R12");

    wr(12'h010, NS_SET[31:0]); wr(12'h014, NS_SET[63:32]);
    wr(12'h018, NS_CLR[31:0]); wr(12'h01C, NS_CLR[63:32]);
    wr(12'h050, SE_SET[31:0]); wr(12'h054, SE_SET[63:32]);
    rd(12'h010, NS_SET[31:0], "R2"); rd(12'h014, NS_SET[63:32], "R2");
    rd(12'h018, NS_CLR[31:0], "R2"); rd(12'h01C, NS_CLR[63:32], "R2");
    rd(12'h050, SE_SET[31:0], "R2"); rd(12'h054, SE_SET[63:32], "R2");

    wr(lo(206), 32'hFFFF_FFFF); rd(lo(206), 32'hF100_03FF, "R1");
    wr(lo(206), 32'd0);         rd(lo(206), 32'd0, "R1");

    wr(lo(207), 32'hFFFF_FFFF); rd(lo(207), 32'd0, "R3");
    wr(12'h020, 32'h1234_5678); rd(12'h020, 32'd0, "R3");
    wr(12'h101, 32'hFFFF_FFFF); rd(lo(0), 32'd0, "R3");
    rd(12'h012, 32'd0, "R3");

    // R4 R5 R6 R7 sweep
    for (int li = 0; li < 5; li++)
      for (int en = 0; en < 2; en++)
        for (int ed = 0; ed < 2; ed++)
          for (int gi = 0; gi < 4; gi++) begin
            int n = lines[li];
            logic [9:0] v = 10'((n*13 + gi*5 + ed) & 32'h3ff);
            logic [2:0] g = grps[gi];
            wr(lo(n), cw(en[0], ed[0], g, v));
            pulse(n, 8, 8);
            if (en == 1 && (g == 3'd0 || g == 3'd4)) expect_msg(g == 3'd4 ? SE_SET : NS_SET, v);
            if (en == 1 && g == 3'd0 && ed == 0) expect_msg(NS_CLR, v);
            compare(g == 3'd4 ? "R6" : (en == 0 || g != 3'd0) ? "R7" : ed == 1 ? "R5" : "R4");
            wr(lo(n), 32'd0);
          end

    // R8 R9 R10: stalled priority and merging
    wr(lo(0), cw(1, 1, 3'd0, 10'h100)); wr(lo(3), cw(1, 1, 3'd0, 10'h103));
    wr(lo(9), cw(1, 1, 3'd0, 10'h109)); wr(lo(206), cw(1, 1, 3'd4, 10'h2CE));
    @(negedge clk); ready = 1'b0;
    pulse(9, 3, 3); pulse(206, 3, 3); pulse(3, 3, 3); pulse(0, 3, 3); pulse(3, 3, 3);
    tick(5); #1;
    chk(valid && maddr == NS_SET && mdata == 32'h109, "R9", maddr, NS_SET);
    @(negedge clk); ready = 1'b1;
    expect_msg(NS_SET, 10'h109); expect_msg(NS_SET, 10'h100);
    expect_msg(NS_SET, 10'h103); expect_msg(SE_SET, 10'h2CE);
    compare("R8");

    // R8 set before clear on one line
    wr(lo(5), cw(1, 0, 3'd0, 10'h055));
    @(negedge clk); ready = 1'b0;
    pulse(0, 3, 3); pulse(5, 4, 4);
    @(negedge clk); ready = 1'b1;
    expect_msg(NS_SET, 10'h100); expect_msg(NS_SET, 10'h055); expect_msg(NS_CLR, 10'h055);
    compare("R8");

    // R10 re-rise cancels pending clear
    @(negedge clk); irq[5] = 1'b1; tick(8);
    expect_msg(NS_SET, 10'h055); compare("R10");
    @(negedge clk); ready = 1'b0;
    pulse(0, 3, 3);
    irq[5] = 1'b0; tick(5); irq[5] = 1'b1; tick(5);
    @(negedge clk); ready = 1'b1;
    expect_msg(NS_SET, 10'h100); compare("R10");
    @(negedge clk); irq[5] = 1'b0; tick(8);
    expect_msg(NS_CLR, 10'h055); compare("R10");

    // R11 config write discards pending
    wr(lo(5), cw(1, 1, 3'd0, 10'h055));
    @(negedge clk); ready = 1'b0;
    pulse(0, 3, 3); pulse(5, 3, 3);
    wr(lo(5), cw(1, 1, 3'd0, 10'h055));
    @(negedge clk); ready = 1'b1;
    expect_msg(NS_SET, 10'h100); compare("R11");

    report();
  end
endmodule